// File: doc/BRIEF.md
# Per-Core Circular Thread Run Queue

This block keeps the threads that are waiting for one core in a circular queue. Only the thread at the head runs on the core, and it keeps running until the core raises one of three events: the thread migrated away, the thread completed, or the thread blocked on I/O. A thread that migrates or completes leaves the queue and is shown once on an exit port. A thread that blocks is not dropped: it is re-queued at the tail, so the next waiting thread becomes the head.

Arriving threads are offered on an enqueue port with a ready/valid handshake. Each entry carries a thread ID, a pointer to the thread's saved context and a core ID. The head entry is always shown on the head port with a valid flag, so the core's context-switch logic can load it. If an enqueue and a head event arrive in the same cycle, both take effect: the event is applied first, and the new thread lands behind any entry the event re-queued.

Top module: `thread_run_queue`

## Requirements
- R1: After reset, head_valid and exit_valid are 0 and enq_ready is 1.
- R2: An enqueue is accepted when enq_valid and enq_ready are both 1. Threads reach the head in the order they were accepted, and the head port shows the stored ID (12 bits), context pointer (48 bits) and core ID (4 bits) unchanged.
- R3: The queue holds at most DEPTH (default 30) threads. enq_ready is 0 exactly when DEPTH threads are held, and an enqueue offered in that state changes nothing.
- R4: A migrate or complete event with head_valid = 1 removes the head. In the next cycle, and only that cycle, exit_valid is 1 and exit_id and exit_ctx carry the removed thread; exit_done is 1 for complete and 0 for migrate.
- R5: A block event with head_valid = 1 moves the head thread to the tail and advances the head. Occupancy is unchanged and exit_valid stays 0.
- R6: When a single thread is held and it blocks, that same thread is the head again in the next cycle.
- R7: When several events are raised together, complete takes precedence over migrate and migrate over block. Only one head action is applied per cycle.
- R8: When an enqueue is accepted in the same cycle as a head event, the event is applied first and the new thread is placed behind any entry the event re-queued.
- R9: While the queue is empty (head_valid = 0), event inputs have no effect: no exit is shown and the queue stays empty unless a thread is enqueued.
- R10: With no event raised, the head thread stays at the head, whatever else is enqueued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enq_valid | input | 1 | An arriving thread is offered |
| enq_ready | output | 1 | Queue can accept a thread (not full) |
| enq_id | input | 12 | Arriving thread ID |
| enq_ctx | input | 48 | Arriving thread context pointer |
| enq_core | input | 4 | Arriving thread core ID |
| head_valid | output | 1 | Queue holds at least one thread |
| head_id | output | 12 | ID of the running (head) thread |
| head_ctx | output | 48 | Context pointer of the head thread |
| head_core | output | 4 | Core ID of the head thread |
| evt_migrate | input | 1 | Head thread migrated to another core |
| evt_complete | input | 1 | Head thread completed |
| evt_block | input | 1 | Head thread blocked on I/O |
| exit_valid | output | 1 | One-cycle pulse: a thread left the queue |
| exit_done | output | 1 | 1 if the leaving thread completed, 0 if it migrated |
| exit_id | output | 12 | ID of the leaving thread |
| exit_ctx | output | 48 | Context pointer of the leaving thread |

## Verification
On every cycle, the assertions check that an exit pulse is always caused by a pop of a valid head and carries that head's ID and the complete-over-migrate reason. They also check that a block keeps occupancy and raises no exit, that an empty queue ignores events, that a lone blocked thread returns as head, that an idle head holds, and that the count never passes the capacity. The full ordering of threads after rotations, wrap-around of the circular storage, and the placement of a same-cycle enqueue behind a re-queued head can only be shown by the bench. Its reference model tracks the whole queue contents through directed and random scenarios.

// File: rtl/trq_pkg.sv
package trq_pkg;

    // Action taken on the head entry in a given cycle
    typedef enum logic [1:0] {
        ACT_NONE   = 2'd0,
        ACT_POP    = 2'd1,
        ACT_ROTATE = 2'd2
    } trq_act_e;

endpackage

// File: rtl/trq_evt_decode.sv
module trq_evt_decode
    import trq_pkg::*;
(
    input  logic     head_valid,
    input  logic     evt_migrate,
    input  logic     evt_complete,
    input  logic     evt_block,
    output trq_act_e act,
    output logic     leave_done
);

    // Priority: complete, then migrate, then block. Nothing happens when empty.
    always_comb begin
        act        = ACT_NONE;
        leave_done = evt_complete;
        if (head_valid) begin
            if (evt_complete || evt_migrate) begin
                act = ACT_POP;
            end else if (evt_block) begin
                act = ACT_ROTATE;
            end
        end
    end

endmodule

// File: rtl/trq_ptr_ctrl.sv
module trq_ptr_ctrl
    import trq_pkg::*;
#(
    parameter int DEPTH = 30,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  trq_act_e         act,
    input  logic             enq_fire,
    output logic [PTR_W-1:0] head_ptr,
    output logic [CNT_W-1:0] count,
    output logic             rot_wr_en,
    output logic [PTR_W-1:0] rot_wr_addr,
    output logic             enq_wr_en,
    output logic [PTR_W-1:0] enq_wr_addr
);

    typedef struct packed {
        logic [PTR_W-1:0] head;
        logic [PTR_W-1:0] tail;
        logic [CNT_W-1:0] count;
    } ptr_state_t;

    ptr_state_t st_d, st_q;

    function automatic logic [PTR_W-1:0] wrap_inc(input logic [PTR_W-1:0] p);
        if (p == PTR_W'(DEPTH - 1)) begin
            return '0;
        end
        return p + PTR_W'(1);
    endfunction

    logic [PTR_W-1:0] tail_after_evt;

    always_comb begin
        st_d           = st_q;
        rot_wr_en      = 1'b0;
        rot_wr_addr    = st_q.tail;
        tail_after_evt = st_q.tail;

        // Head action comes first
        unique case (act)
            ACT_POP: begin
                st_d.head  = wrap_inc(st_q.head);
                st_d.count = st_q.count - CNT_W'(1);
            end
            ACT_ROTATE: begin
                rot_wr_en      = 1'b1;
                rot_wr_addr    = st_q.tail;
                st_d.head      = wrap_inc(st_q.head);
                tail_after_evt = wrap_inc(st_q.tail);
            end
            default: begin
            end
        endcase

        // New arrival lands behind anything the event re-queued
        enq_wr_en   = enq_fire;
        enq_wr_addr = tail_after_evt;
        if (enq_fire) begin
            st_d.tail  = wrap_inc(tail_after_evt);
            st_d.count = st_d.count + CNT_W'(1);
        end else begin
            st_d.tail = tail_after_evt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign head_ptr = st_q.head;
    assign count    = st_q.count;

endmodule

// File: rtl/trq_slot_store.sv
module trq_slot_store #(
    parameter int DEPTH   = 30,
    parameter int ENTRY_W = 64,
    localparam int PTR_W  = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rot_wr_en,
    input  logic [PTR_W-1:0]   rot_wr_addr,
    input  logic [ENTRY_W-1:0] rot_wr_data,
    input  logic               enq_wr_en,
    input  logic [PTR_W-1:0]   enq_wr_addr,
    input  logic [ENTRY_W-1:0] enq_wr_data,
    input  logic [PTR_W-1:0]   rd_addr,
    output logic [ENTRY_W-1:0] rd_data
);

    logic [ENTRY_W-1:0] slot_d [DEPTH];
    logic [ENTRY_W-1:0] slot_q [DEPTH];

    // Two write ports; the controller never aims them at the same slot
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            slot_d[i] = slot_q[i];
            if (rot_wr_en && (rot_wr_addr == PTR_W'(i))) begin
                slot_d[i] = rot_wr_data;
            end
            if (enq_wr_en && (enq_wr_addr == PTR_W'(i))) begin
                slot_d[i] = enq_wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                slot_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                slot_q[i] <= slot_d[i];
            end
        end
    end

    // Read mux limited to the slots that exist
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (rd_addr == PTR_W'(i)) begin
                rd_data = slot_q[i];
            end
        end
    end

endmodule

// File: rtl/thread_run_queue.sv
module thread_run_queue
    import trq_pkg::*;
#(
    parameter int DEPTH  = 30,
    parameter int ID_W   = 12,
    parameter int CTX_W  = 48,
    parameter int CORE_W = 4,
    localparam int PTR_W   = $clog2(DEPTH),
    localparam int CNT_W   = $clog2(DEPTH + 1),
    localparam int ENTRY_W = ID_W + CTX_W + CORE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enq_valid,
    output logic              enq_ready,
    input  logic [ID_W-1:0]   enq_id,
    input  logic [CTX_W-1:0]  enq_ctx,
    input  logic [CORE_W-1:0] enq_core,
    output logic              head_valid,
    output logic [ID_W-1:0]   head_id,
    output logic [CTX_W-1:0]  head_ctx,
    output logic [CORE_W-1:0] head_core,
    input  logic              evt_migrate,
    input  logic              evt_complete,
    input  logic              evt_block,
    output logic              exit_valid,
    output logic              exit_done,
    output logic [ID_W-1:0]   exit_id,
    output logic [CTX_W-1:0]  exit_ctx
);

    typedef struct packed {
        logic [CORE_W-1:0] core;
        logic [CTX_W-1:0]  ctx;
        logic [ID_W-1:0]   id;
    } entry_t;

    typedef struct packed {
        logic             valid;
        logic             done;
        logic [ID_W-1:0]  id;
        logic [CTX_W-1:0] ctx;
    } exit_t;

    trq_act_e         act;
    logic             leave_done;
    logic             enq_fire;
    logic [PTR_W-1:0] head_ptr;
    logic [CNT_W-1:0] count_q;
    logic             rot_wr_en;
    logic [PTR_W-1:0] rot_wr_addr;
    logic             enq_wr_en;
    logic [PTR_W-1:0] enq_wr_addr;
    entry_t           head_entry;
    entry_t           new_entry;
    exit_t            exit_d, exit_q;

    assign head_valid = (count_q != '0);
    assign enq_ready  = (count_q != CNT_W'(DEPTH));
    assign enq_fire   = enq_valid && enq_ready;

    assign new_entry.core = enq_core;
    assign new_entry.ctx  = enq_ctx;
    assign new_entry.id   = enq_id;

    trq_evt_decode u_decode (
        .head_valid   (head_valid),
        .evt_migrate  (evt_migrate),
        .evt_complete (evt_complete),
        .evt_block    (evt_block),
        .act          (act),
        .leave_done   (leave_done)
    );

    trq_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
        .clk         (clk),
        .rst_n       (rst_n),
        .act         (act),
        .enq_fire    (enq_fire),
        .head_ptr    (head_ptr),
        .count       (count_q),
        .rot_wr_en   (rot_wr_en),
        .rot_wr_addr (rot_wr_addr),
        .enq_wr_en   (enq_wr_en),
        .enq_wr_addr (enq_wr_addr)
    );

    trq_slot_store #(.DEPTH(DEPTH), .ENTRY_W(ENTRY_W)) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .rot_wr_en   (rot_wr_en),
        .rot_wr_addr (rot_wr_addr),
        .rot_wr_data (head_entry),
        .enq_wr_en   (enq_wr_en),
        .enq_wr_addr (enq_wr_addr),
        .enq_wr_data (new_entry),
        .rd_addr     (head_ptr),
        .rd_data     (head_entry)
    );

    assign head_id   = head_entry.id;
    assign head_ctx  = head_entry.ctx;
    assign head_core = head_entry.core;

    // Exit port: one-cycle report of a removed thread
    always_comb begin
        exit_d       = exit_q;
        exit_d.valid = (act == ACT_POP);
        if (act == ACT_POP) begin
            exit_d.done = leave_done;
            exit_d.id   = head_entry.id;
            exit_d.ctx  = head_entry.ctx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            exit_q <= '0;
        end else begin
            exit_q <= exit_d;
        end
    end

    assign exit_valid = exit_q.valid;
    assign exit_done  = exit_q.done;
    assign exit_id    = exit_q.id;
    assign exit_ctx   = exit_q.ctx;

endmodule

// File: rtl/trq_checker.sv
module trq_checker #(
    parameter int DEPTH = 30,
    parameter int ID_W  = 12,
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enq_valid,
    input logic             enq_ready,
    input logic             head_valid,
    input logic [ID_W-1:0]  head_id,
    input logic             evt_migrate,
    input logic             evt_complete,
    input logic             evt_block,
    input logic             exit_valid,
    input logic             exit_done,
    input logic [ID_W-1:0]  exit_id,
    input logic [CNT_W-1:0] count
);

    logic block_only;
    logic no_evt;
    assign block_only = evt_block && !evt_migrate && !evt_complete;
    assign no_evt     = !evt_block && !evt_migrate && !evt_complete;

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (count <= CNT_W'(DEPTH)) && (!enq_ready == (count == CNT_W'(DEPTH))));

    assert_exit_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        exit_valid |-> $past(head_valid && (evt_migrate || evt_complete)));

    assert_exit_id_R4: assert property (@(posedge clk) disable iff (!rst_n)
        exit_valid |-> (exit_id == $past(head_id)));

    assert_block_no_exit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (head_valid && block_only) |=> !exit_valid);

    assert_block_keeps_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (head_valid && block_only && !(enq_valid && enq_ready)) |=> (count == $past(count)));

    assert_lone_block_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((count == CNT_W'(1)) && block_only) |=> (head_valid && head_id == $past(head_id)));

    assert_priority_R7: assert property (@(posedge clk) disable iff (!rst_n)
        exit_valid |-> (exit_done == $past(evt_complete)));

    assert_empty_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!head_valid && !enq_valid) |=> (!head_valid && !exit_valid));

    assert_head_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (head_valid && no_evt) |=> (head_valid && head_id == $past(head_id)));

endmodule

bind thread_run_queue trq_checker #(
    .DEPTH (DEPTH),
    .ID_W  (ID_W),
    .CNT_W (CNT_W)
) u_trq_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .enq_valid    (enq_valid),
    .enq_ready    (enq_ready),
    .head_valid   (head_valid),
    .head_id      (head_id),
    .evt_migrate  (evt_migrate),
    .evt_complete (evt_complete),
    .evt_block    (evt_block),
    .exit_valid   (exit_valid),
    .exit_done    (exit_done),
    .exit_id      (exit_id),
    .count        (count_q)
);

// File: tb/thread_run_queue_bench.sv
`timescale 1ns/1ps
module thread_run_queue_bench;

    localparam int DEPTH = 30;

    typedef struct packed {
        logic [3:0]  core;
        logic [47:0] ctx;
        logic [11:0] id;
    } ent_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enq_valid = 1'b0;
    logic        enq_ready;
    logic [11:0] enq_id = '0;
    logic [47:0] enq_ctx = '0;
    logic [3:0]  enq_core = '0;
    logic        head_valid;
    logic [11:0] head_id;
    logic [47:0] head_ctx;
    logic [3:0]  head_core;
    logic        evt_migrate = 1'b0;
    logic        evt_complete = 1'b0;
    logic        evt_block = 1'b0;
    logic        exit_valid;
    logic        exit_done;
    logic [11:0] exit_id;
    logic [47:0] exit_ctx;

    always #2 clk = ~clk;

    thread_run_queue u_thread_run_queue (
        .clk          (clk),
        .rst_n        (rst_n),
        .enq_valid    (enq_valid),
        .enq_ready    (enq_ready),
        .enq_id       (enq_id),
        .enq_ctx      (enq_ctx),
        .enq_core     (enq_core),
        .head_valid   (head_valid),
        .head_id      (head_id),
        .head_ctx     (head_ctx),
        .head_core    (head_core),
        .evt_migrate  (evt_migrate),
        .evt_complete (evt_complete),
        .evt_block    (evt_block),
        .exit_valid   (exit_valid),
        .exit_done    (exit_done),
        .exit_id      (exit_id),
        .exit_ctx     (exit_ctx)
    );

    int    checks = 0;
    int    failures = 0;
    string cur_req = "R1";
    bit    started = 1'b0;
    int    next_id = 1;

    // Reference model
    ent_t  mq[$];
    bit    x_valid = 1'b0;
    bit    x_done = 1'b0;
    ent_t  x_ent = '0;

    task automatic chk(input bit ok, input string what, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s got=%h exp=%h", cur_req, what, got, exp);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            mq.delete();
            x_valid = 1'b0;
        end else begin
            bit room;
            room = (mq.size() < DEPTH);
            x_valid = 1'b0;
            if (mq.size() > 0) begin
                if (evt_complete || evt_migrate) begin
                    x_ent   = mq.pop_front();
                    x_valid = 1'b1;
                    x_done  = evt_complete;
                end else if (evt_block) begin
                    ent_t e;
                    e = mq.pop_front();
                    mq.push_back(e);
                end
            end
            if (enq_valid && room) begin
                ent_t n;
                n.id = enq_id; n.ctx = enq_ctx; n.core = enq_core;
                mq.push_back(n);
            end
            started = 1'b1;
        end
    end

    always @(negedge clk) begin
        if (rst_n && started) begin
            chk(head_valid == (mq.size() != 0), "head_valid", 64'(head_valid), 64'(mq.size() != 0));
            chk(enq_ready == (mq.size() < DEPTH), "enq_ready", 64'(enq_ready), 64'(mq.size() < DEPTH));
            if (mq.size() != 0) begin
                chk(head_id == mq[0].id, "head_id", 64'(head_id), 64'(mq[0].id));
                chk(head_ctx == mq[0].ctx, "head_ctx", 64'(head_ctx), 64'(mq[0].ctx));
                chk(head_core == mq[0].core, "head_core", 64'(head_core), 64'(mq[0].core));
            end
            chk(exit_valid == x_valid, "exit_valid", 64'(exit_valid), 64'(x_valid));
            if (x_valid) begin
                chk(exit_id == x_ent.id, "exit_id", 64'(exit_id), 64'(x_ent.id));
                chk(exit_ctx == x_ent.ctx, "exit_ctx", 64'(exit_ctx), 64'(x_ent.ctx));
                chk(exit_done == x_done, "exit_done", 64'(exit_done), 64'(x_done));
            end
        end
    end

    task automatic step(input bit en, input bit mig, input bit cmp, input bit blk);
        @(negedge clk);
        #1;
        enq_valid    = en;
        enq_id       = 12'(next_id);
        enq_ctx      = {16'hC0DE, 32'($urandom)};
        enq_core     = 4'($urandom);
        evt_migrate  = mig;
        evt_complete = cmp;
        evt_block    = blk;
        if (en) next_id++;
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog all-requirements got=running exp=finished");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        cur_req = "R1";
        chk(head_valid == 1'b0, "reset head_valid", 64'(head_valid), 64'd0);
        chk(exit_valid == 1'b0, "reset exit_valid", 64'(exit_valid), 64'd0);
        chk(enq_ready == 1'b1, "reset enq_ready", 64'(enq_ready), 64'd1);
        rst_n = 1'b1;

        cur_req = "R9";
        step(0, 1, 0, 0); step(0, 0, 1, 0); step(0, 0, 0, 1); step(0, 1, 1, 1);

        cur_req = "R2";
        for (int i = 0; i < 5; i++) step(1, 0, 0, 0);
        cur_req = "R10";
        for (int i = 0; i < 3; i++) step(0, 0, 0, 0);
        step(1, 0, 0, 0);

        cur_req = "R5";
        step(0, 0, 0, 1); step(0, 0, 0, 1); step(0, 0, 0, 0);

        cur_req = "R4";
        step(0, 1, 0, 0); step(0, 0, 0, 0); step(0, 0, 1, 0); step(0, 0, 0, 0);

        cur_req = "R7";
        step(0, 1, 1, 1); step(0, 1, 0, 1); step(0, 0, 1, 1); step(0, 0, 0, 0);

        cur_req = "R6";
        while (mq.size() > 1) step(0, 0, 1, 0);
        step(0, 0, 0, 0);
        step(0, 0, 0, 1); step(0, 0, 0, 1); step(0, 0, 0, 0);

        cur_req = "R8";
        step(1, 0, 0, 1); step(0, 0, 0, 0);
        step(1, 0, 0, 1); step(0, 0, 0, 0);
        step(1, 0, 1, 0); step(1, 1, 0, 0); step(0, 0, 0, 0);

        cur_req = "R3";
        while (mq.size() < DEPTH - 1) step(1, 0, 0, 0);
        step(1, 0, 0, 1);
        step(0, 0, 0, 0);
        step(1, 0, 0, 0); step(1, 0, 0, 0); step(1, 0, 0, 1);
        step(0, 0, 0, 0);
        @(negedge clk);
        chk(enq_ready == 1'b0, "full enq_ready", 64'(enq_ready), 64'd0);
        for (int i = 0; i < DEPTH + 3; i++) step(0, 0, 0, 1);
        step(1, 0, 1, 0); step(0, 0, 0, 0);
        while (mq.size() > 0) step(0, 0, 1, 0);
        step(0, 0, 0, 0);

        cur_req = "R2";
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = int'($urandom_range(0, 99));
            step($urandom_range(0, 99) < 45, r < 8, r >= 8 && r < 16, r >= 16 && r < 30);
        end
        step(0, 0, 0, 0);
        step(0, 0, 0, 0);
        @(negedge clk);
        summary();
        $finish;
    end

endmodule